// File: doc/BRIEF.md
# Regulator Voltage Code Ramp Generator

This block produces the 7-bit voltage code that sets a step-down converter's output. Each code step is 25 mV, with code 0x00 standing for 0.825 V and code 0x6F for 3.600 V. While the control source selects the fuse default, the live code simply follows the fuse code. Once the host selects register control, the live code walks toward the host's target code one step at a time, up or down, at one of eight programmable slew rates.

The 3-bit slew setting picks a rate of 0.225 mV/µs × 2^setting, so 000 gives 0.225 mV/µs and 111 gives 28.8 mV/µs. One 25 mV step therefore takes (111.1 / 2^setting) µs. The block turns this into a clock-cycle interval, `CLK_HZ/9000` shifted right by the setting, with a floor of one cycle.

The intended host sequence is to load the target first and then switch the source to register control. A target can be rewritten while a ramp is under way. The ramp then turns toward the new value from wherever the live code stands, and the code never jumps.

Top module: `vramp_top`

## Requirements
- R1: While `use_host` is 0, `live_code` takes the value of `fuse_code` at the next clock edge.
- R2: During reset `live_code` is 0x00 and `busy` is 0.
- R3: With `use_host` at 1 and the clamped target above `live_code`, `live_code` rises by exactly one after every interval of I consecutive busy cycles.
- R4: With `use_host` at 1 and the clamped target below `live_code`, `live_code` falls by exactly one after every interval of I busy cycles.
- R5: The interval is I = max(1, (CLK_HZ/9000) >> slew_sel), so each higher slew code halves the interval.
- R6: `busy` is 1 exactly when `use_host` is 1 and `live_code` differs from the clamped target. Once they are equal, `live_code` holds.
- R7: Changing the target mid-ramp redirects the ramp from the present `live_code`. The interval count is kept, and no step is larger than one.
- R8: Target codes above 0x6F are treated as 0x6F.
- R9: While `use_host` is 0, the values of `target_code` and `slew_sel` have no effect on `live_code`.
- R10: Clearing `use_host` mid-ramp returns `live_code` to `fuse_code` at the next edge and discards the partial interval.
- R11: If `slew_sel` is raised mid-ramp so that the busy cycles already counted reach the new interval, the next step occurs at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| target_code | input | 7 | Host target voltage code |
| slew_sel | input | 3 | Slew setting, rate = 0.225 mV/µs × 2^slew_sel |
| use_host | input | 1 | Control source: 0 fuse default, 1 host target |
| fuse_code | input | 7 | Fuse default voltage code |
| live_code | output | 7 | Present voltage code sent to the regulator |
| busy | output | 1 | Ramp in progress |

## Verification
The delicate coincidence is a step becoming due on the same edge that the host changes the target direction, or changes the control source or slew setting. The bench provokes this by cutting a ramp into segments whose lengths place the change exactly on the edge where the interval expires. In the redirect case, that edge must carry a step toward the new target. In the source-drop case, the edge must load the fuse code and no step. A cycle-level expectation built from the requirements is compared every cycle against both `live_code` and `busy`. This exposes an off-by-one step, a skipped step or a doubled step.

// File: rtl/vramp_pkg.sv
package vramp_pkg;
    localparam int CODE_W = 7;
    localparam int SLEW_W = 3;
    localparam int NUM_RATES = 1 << SLEW_W;
    // one 25 mV step at 0.225 mV/us lasts 1/9000 s
    localparam int STEP_DIV = 9000;

    typedef logic [CODE_W-1:0] vcode_t;
    typedef logic [SLEW_W-1:0] slew_t;

    localparam vcode_t CODE_MAX = 7'h6F;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;
endpackage

// File: rtl/vramp_target_clamp.sv
module vramp_target_clamp
    import vramp_pkg::*;
(
    input  vcode_t raw_code,
    output vcode_t safe_code
);
    always_comb begin
        if (raw_code > CODE_MAX) safe_code = CODE_MAX;
        else                     safe_code = raw_code;
    end
endmodule

// File: rtl/vramp_interval_timer.sv
module vramp_interval_timer
    import vramp_pkg::*;
#(
    parameter int BASE_CYC = 22222,
    localparam int CNT_W = $clog2(BASE_CYC + 1)
)(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  slew_t slew_sel,
    output logic  tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_q, st_d;
    logic [CNT_W-1:0] ivl_tab [NUM_RATES];
    logic [CNT_W-1:0] limit;

    genvar g;
    generate
        for (g = 0; g < NUM_RATES; g++) begin : g_rate
            localparam int RAW = BASE_CYC >> g;
            localparam int IVL = (RAW < 1) ? 1 : RAW;
            assign ivl_tab[g] = CNT_W'(IVL);
        end
    endgenerate

    assign limit = ivl_tab[slew_sel];

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= limit - CNT_W'(1)) begin
            tick     = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.cnt == '0));
endmodule

// File: rtl/vramp_stepper.sv
module vramp_stepper
    import vramp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   use_host,
    input  vcode_t fuse_code,
    input  vcode_t tgt_code,
    input  logic   tick,
    output vcode_t live_code,
    output logic   busy
);
    typedef struct packed {
        vcode_t live;
    } step_state_t;

    step_state_t st_q, st_d;
    dir_e dir;

    always_comb begin
        busy = use_host && (st_q.live != tgt_code);
        if (!busy)                     dir = DIR_HOLD;
        else if (st_q.live < tgt_code) dir = DIR_UP;
        else                           dir = DIR_DOWN;
    end

    always_comb begin
        st_d = st_q;
        if (!use_host) begin
            st_d.live = fuse_code;
        end else if (tick) begin
            unique case (dir)
                DIR_UP:   st_d.live = st_q.live + 7'd1;
                DIR_DOWN: st_d.live = st_q.live - 7'd1;
                default:  st_d.live = st_q.live;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live_code = st_q.live;

    // R1
    fuse_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !use_host |=> (st_q.live == $past(fuse_code)));

    // R7
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_host && $past(use_host)) |->
            ((st_q.live == $past(st_q.live)) ||
             (st_q.live == $past(st_q.live) + 7'd1) ||
             (st_q.live == $past(st_q.live) - 7'd1)));

    // R3
    toward_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_host && $past(use_host) && (st_q.live != $past(st_q.live))) |->
            ((st_q.live > $past(st_q.live)) == ($past(tgt_code) > $past(st_q.live))));

    // R6
    settled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_host && $past(use_host) && ($past(st_q.live) == $past(tgt_code))) |->
            (st_q.live == $past(st_q.live)));
endmodule

// File: rtl/vramp_top.sv
module vramp_top
    import vramp_pkg::*;
#(
    parameter int CLK_HZ = 200_000_000
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] target_code,
    input  logic [2:0] slew_sel,
    input  logic       use_host,
    input  logic [6:0] fuse_code,
    output logic [6:0] live_code,
    output logic       busy
);
    localparam int RAW_BASE = CLK_HZ / STEP_DIV;
    localparam int BASE_CYC = (RAW_BASE < 1) ? 1 : RAW_BASE;

    vcode_t tgt_safe;
    logic   tick;
    logic   busy_int;

    vramp_target_clamp u_clamp (
        .raw_code  (target_code),
        .safe_code (tgt_safe)
    );

    vramp_interval_timer #(.BASE_CYC(BASE_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy_int),
        .slew_sel (slew_sel),
        .tick     (tick)
    );

    vramp_stepper u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .use_host  (use_host),
        .fuse_code (fuse_code),
        .tgt_code  (tgt_safe),
        .tick      (tick),
        .live_code (live_code),
        .busy      (busy_int)
    );

    assign busy = busy_int;

    // R6
    tick_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> busy_int);

    // R8
    clamp_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_host && $past(use_host) && ($past(live_code) <= CODE_MAX)) |->
            (live_code <= CODE_MAX));
endmodule

// File: tb/tb_vramp_top.sv
module tb_vramp_top;
    localparam int CLK_HZ = 2_304_000;   // base interval of 256 cycles
    localparam int BASE   = CLK_HZ / 9000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] target_code = 7'h20;
    logic [2:0] slew_sel = 3'd1;
    logic       use_host = 1'b0;
    logic [6:0] fuse_code = 7'h10;
    logic [6:0] live_code;
    logic       busy;

    always #2.5 clk = ~clk;

    vramp_top #(.CLK_HZ(CLK_HZ)) dut (
        .clk(clk), .rst_n(rst_n), .target_code(target_code), .slew_sel(slew_sel),
        .use_host(use_host), .fuse_code(fuse_code), .live_code(live_code), .busy(busy)
    );

    typedef struct {
        logic [6:0] live;
        logic       bsy;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int failures = 0;
    int m_live = 0;
    int m_cnt = 0;
    bit done = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: apply one input set for n cycles, queue expected per edge
    task automatic seg(input bit host, input int tgt, input int slew,
                       input int fuse, input int n, input string tag);
        int ivl;
        int ct;
        exp_t e;
        @(negedge clk);
        use_host = host; target_code = 7'(tgt); slew_sel = 3'(slew); fuse_code = 7'(fuse);
        ivl = BASE >> slew;
        if (ivl < 1) ivl = 1;
        ct = (tgt > 'h6F) ? 'h6F : tgt;
        for (int k = 0; k < n; k++) begin
            if (!host) begin
                m_live = fuse; m_cnt = 0;
            end else if (m_live != ct) begin
                if (m_cnt >= ivl - 1) begin
                    m_live = (m_live < ct) ? m_live + 1 : m_live - 1;
                    m_cnt = 0;
                end else begin
                    m_cnt++;
                end
            end else begin
                m_cnt = 0;
            end
            e.live = 7'(m_live);
            e.bsy  = host && (m_live != ct);
            e.tag  = tag;
            exp_q.push_back(e);
        end
        repeat (n) @(posedge clk);
    endtask

    // monitor: compare one expected item per edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " live_code"}, int'(live_code), int'(e.live));
                check({e.tag, " busy"}, int'(busy), int'(e.bsy));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R2 reset live_code", int'(live_code), 0);
        check("R2 reset busy", int'(busy), 0);
        rst_n = 1'b1;
        m_live = 0; m_cnt = 0;
        seg(0, 'h20, 1, 'h10, 3, "R1 fuse follow");
        seg(0, 'h55, 5, 'h10, 3, "R9 target ignored");
        seg(0, 'h55, 5, 'h14, 2, "R1 fuse change");
        seg(1, 'h18, 7, 'h14, 14, "R3 ramp up");
        seg(1, 'h15, 6, 'h14, 16, "R4 ramp down");
        seg(1, 'h17, 3, 'h14, 100, "R5 interval 32");
        seg(1, 'h18, 0, 'h14, 260, "R5 interval 256");
        seg(1, 'h7F, 7, 'h14, 182, "R8 clamp");
        seg(1, 'h60, 6, 'h14, 10, "R6 down toward 0x60");
        seg(1, 'h6F, 6, 'h14, 14, "R7 redirect up");
        seg(1, 'h60, 6, 'h14, 7, "R4 down before tick");
        seg(1, 'h70, 6, 'h14, 10, "R7 redirect on tick edge");
        seg(1, 'h60, 0, 'h14, 100, "R5 slow partial");
        seg(1, 'h60, 7, 'h14, 6, "R11 slew raised");
        seg(1, 'h40, 7, 'h22, 5, "R3 before drop");
        seg(0, 'h40, 7, 'h22, 3, "R10 source drop");
        seg(1, 'h24, 7, 'h22, 8, "R6 settle");
        repeat (3) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule